// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides what a single memory access may do once translation has located its page entry and its segment. It combines two independent permission sources. The first is a protection code carried in the page entry, interpreted under a key bit chosen from the segment by the current privilege level. The second is a per-class mask register with two bits per class, where the page entry names the class. The granted read/write/execute set is the AND of the two sources. The block flags a fault when the access type needs a right that is missing.

On an instruction fetch fault the block returns an instruction-fault code. On a data fault it returns a status word. That word has separate bits for a protection-code violation and a mask violation, plus a bit that marks the access as a store. All results are registered, so they appear one clock after the inputs are sampled. Storage of the page entries and the table walk live elsewhere.

Top module: `page_perm_check`

## Requirements
- R1: While reset is asserted, and after it until the first sampling edge, `perm_q`, `fault_q`, `icode_q` and `dstat_q` are all zero.
- R2: The protection key bit is `seg_key_user` when `priv_user` is 1 and `seg_key_super` when it is 0.
- R3: The 3-bit protection code is {`pte_word[63]`, `pte_word[1:0]`}. With key 0: codes 0, 1 and 2 grant read and write, codes 3 and 6 grant read only, and codes 4, 5 and 7 grant nothing. With key 1: code 2 grants read and write, codes 1, 3 and 6 grant read only, and codes 0, 4, 5 and 7 grant nothing.
- R4: The code source grants execute only when it grants read and all three of these are clear: the page no-execute bit `pte_word[2]`, the guarded bit `pte_word[3]`, and `seg_noexec`.
- R5: When `mask_en` is 0 the mask source grants read, write and execute whatever `mask_reg` holds.
- R6: When `mask_en` is 1, the class key `pte_word[8:4]` selects `mask_reg[2*(31-key)+1 : 2*(31-key)]`. The upper bit of that field removes write and the lower bit removes read. Execute is never removed by the mask.
- R7: `perm_q` (bit 0 read, bit 1 write, bit 2 execute) is the AND of both sources. `acc_type` is encoded as 0 load, 1 store, 2 fetch and 3 load. `fault_q` is 1 exactly when the right the access needs (read, write or execute) is missing from `perm_q`.
- R8: A faulting fetch sets `icode_q` to 0x10000000 when `seg_noexec` is 1 and to 0x08000000 otherwise. `icode_q` is 0 for any access that does not fault and for any data access.
- R9: A faulting load or store sets `dstat_q` to the OR of three values: 0x08000000 if the code source lacks the needed right, 0x00200000 if the mask source lacks it, and 0x02000000 if the access is a store. `dstat_q` is 0 for any fetch and for any access that does not fault.
- R10: Every output reflects the inputs sampled at the preceding rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pte_word | input | 64 | Second word of the matched page entry |
| seg_key_user | input | 1 | Segment key bit used in user state |
| seg_key_super | input | 1 | Segment key bit used in supervisor state |
| seg_noexec | input | 1 | Segment forbids instruction fetch |
| priv_user | input | 1 | 1 = processor in user state |
| mask_en | input | 1 | Enables the class-mask check |
| mask_reg | input | 64 | Class-mask register, two bits per class |
| acc_type | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 load |
| perm_q | output | 3 | Granted rights {execute, write, read} |
| fault_q | output | 1 | Access is denied |
| icode_q | output | 32 | Instruction fault code |
| dstat_q | output | 32 | Data fault status |

## Verification
The bench sweeps all eight protection codes under both key values and both privilege levels. A swapped key selection or a misplaced table entry would then grant rights to the wrong code. It places the class key at both ends of its range (0 and 31), so reversed field indexing would take its bits from the opposite end of the mask register. It drives faults where only the code source denies, only the mask source denies, or both deny, on loads and on stores. This exposes a status word that credits the wrong source or drops the store bit. Fetches go to pages that are no-execute, guarded, or in a no-execute segment, which tests the priority between the two instruction fault codes. Random vectors cover the combinations between these cases.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
    localparam int PTE_PP_LSB  = 0;
    localparam int PTE_NX_BIT  = 2;
    localparam int PTE_GD_BIT  = 3;
    localparam int PTE_KEY_LSB = 4;
    localparam int PTE_PP0_BIT = 63;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [31:0] ICODE_SEGNX = 32'h1000_0000;
    localparam logic [31:0] ICODE_PROT  = 32'h0800_0000;
    localparam logic [31:0] DST_PROT    = 32'h0800_0000;
    localparam logic [31:0] DST_MASK    = 32'h0020_0000;
    localparam logic [31:0] DST_STORE   = 32'h0200_0000;

    typedef struct packed {
        logic [2:0]  perm;
        logic        fault;
        logic [31:0] icode;
        logic [31:0] dstat;
    } chk_out_t;
endpackage

// File: rtl/pchk_code_table.sv
module pchk_code_table (
    input  logic       key,
    input  logic [2:0] code,
    input  logic       bar_x,
    output logic [2:0] prot
);
    always_comb begin
        prot = 3'b000;
        case ({key, code})
            4'b0_000, 4'b0_001, 4'b0_010: prot[1:0] = 2'b11;
            4'b0_011, 4'b0_110:           prot[0]   = 1'b1;
            4'b1_010:                     prot[1:0] = 2'b11;
            4'b1_001, 4'b1_011, 4'b1_110: prot[0]   = 1'b1;
            default:                      prot      = 3'b000;
        endcase
        prot[2] = prot[0] & ~bar_x;
    end
endmodule

// File: rtl/pchk_mask_sel.sv
module pchk_mask_sel #(
    parameter int KEY_W  = 5,
    parameter int MASK_W = 64
) (
    input  logic              en,
    input  logic [KEY_W-1:0]  key,
    input  logic [MASK_W-1:0] mask,
    output logic [2:0]        prot
);
    localparam int NKEYS = 2 ** KEY_W;
    localparam int AMT_W = KEY_W + 1;

    logic [AMT_W-1:0]  amt;
    logic [MASK_W-1:0] shifted;
    logic [1:0]        fld;

    always_comb begin
        amt     = {~key, 1'b0};
        shifted = mask >> amt;
        fld     = shifted[1:0];
        prot    = en ? {1'b1, ~fld[1], ~fld[0]} : 3'b111;
    end

    initial begin
        if (MASK_W != 2 * NKEYS) $error("mask width must hold two bits per class");
    end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import pchk_pkg::*;
#(
    parameter int KEY_W  = 5,
    parameter int MASK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       pte_word,
    input  logic              seg_key_user,
    input  logic              seg_key_super,
    input  logic              seg_noexec,
    input  logic              priv_user,
    input  logic              mask_en,
    input  logic [MASK_W-1:0] mask_reg,
    input  logic [1:0]        acc_type,
    output logic [2:0]        perm_q,
    output logic              fault_q,
    output logic [31:0]       icode_q,
    output logic [31:0]       dstat_q
);
    logic       sel_key;
    logic [2:0] pp_code;
    logic       bar_x;
    logic [2:0] code_prot;
    logic [2:0] mask_prot;
    logic [2:0] need;
    logic [2:0] final_prot;
    logic       is_fetch;
    logic       is_store;
    chk_out_t   out_d, out_q;

    always_comb begin
        sel_key = priv_user ? seg_key_user : seg_key_super;
        pp_code = {pte_word[PTE_PP0_BIT], pte_word[PTE_PP_LSB+1:PTE_PP_LSB]};
        bar_x   = pte_word[PTE_NX_BIT] | pte_word[PTE_GD_BIT] | seg_noexec;
    end

    pchk_code_table u_code (
        .key   (sel_key),
        .code  (pp_code),
        .bar_x (bar_x),
        .prot  (code_prot)
    );

    pchk_mask_sel #(.KEY_W(KEY_W), .MASK_W(MASK_W)) u_mask (
        .en   (mask_en),
        .key  (pte_word[PTE_KEY_LSB +: KEY_W]),
        .mask (mask_reg),
        .prot (mask_prot)
    );

    always_comb begin
        is_fetch   = (acc_type == ACC_FETCH);
        is_store   = (acc_type == ACC_STORE);
        need       = is_fetch ? 3'b100 : (is_store ? 3'b010 : 3'b001);
        final_prot = code_prot & mask_prot;

        out_d       = '0;
        out_d.perm  = final_prot;
        out_d.fault = |(need & ~final_prot);
        if (out_d.fault && is_fetch) begin
            out_d.icode = seg_noexec ? ICODE_SEGNX : ICODE_PROT;
        end
        if (out_d.fault && !is_fetch) begin
            if (|(need & ~code_prot)) out_d.dstat = out_d.dstat | DST_PROT;
            if (|(need & ~mask_prot)) out_d.dstat = out_d.dstat | DST_MASK;
            if (is_store)             out_d.dstat = out_d.dstat | DST_STORE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign perm_q  = out_q.perm;
    assign fault_q = out_q.fault;
    assign icode_q = out_q.icode;
    assign dstat_q = out_q.dstat;

    // R4: a no-execute segment never yields execute permission
    a_r4_seg_bars_exec: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(seg_noexec) |-> !perm_q[2]);

    // R8: fetch into a no-execute segment reports the segment code
    a_r8_segnx_code: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(seg_noexec) && $past(acc_type) == ACC_FETCH
        |-> fault_q && icode_q == ICODE_SEGNX && dstat_q == 32'd0);

    // R7: no fault means no codes at all
    a_r7_quiet_when_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_q |-> icode_q == 32'd0 && dstat_q == 32'd0);

    // R9: a faulting store always carries the store flag and a cause
    a_r9_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(acc_type) == ACC_STORE && fault_q
        |-> dstat_q[25] && (dstat_q[27] || dstat_q[21]));

    // R5: with the mask disabled a mask cause never appears
    a_r5_mask_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(mask_en) |-> !dstat_q[21]);
endmodule

// File: tb/test_page_perm_check.sv
module test_page_perm_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] pte_word = '0;
    logic        seg_key_user = 1'b0, seg_key_super = 1'b0, seg_noexec = 1'b0;
    logic        priv_user = 1'b0, mask_en = 1'b0;
    logic [63:0] mask_reg = '0;
    logic [1:0]  acc_type = '0;
    logic [2:0]  perm_q;
    logic        fault_q;
    logic [31:0] icode_q, dstat_q;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    page_perm_check i_page_perm_check (
        .clk(clk), .rst_n(rst_n), .pte_word(pte_word),
        .seg_key_user(seg_key_user), .seg_key_super(seg_key_super),
        .seg_noexec(seg_noexec), .priv_user(priv_user), .mask_en(mask_en),
        .mask_reg(mask_reg), .acc_type(acc_type),
        .perm_q(perm_q), .fault_q(fault_q), .icode_q(icode_q), .dstat_q(dstat_q)
    );

    // behavioural reference of the requirements
    task automatic model(output logic [2:0] e_perm, output logic e_fault,
                         output logic [31:0] e_icode, output logic [31:0] e_dstat);
        int  k, c, ck, off;
        bit  cr, cw, cx, mr, mw, need_r, need_w, need_x, miss;
        k = priv_user ? int'(seg_key_user) : int'(seg_key_super);     // R2
        c = int'(pte_word[63]) * 4 + int'(pte_word[1:0]);             // R3
        cr = 0; cw = 0;
        if (k == 0) begin
            if (c <= 2) begin cr = 1; cw = 1; end
            else if (c == 3 || c == 6) cr = 1;
        end else begin
            if (c == 2) begin cr = 1; cw = 1; end
            else if (c == 1 || c == 3 || c == 6) cr = 1;
        end
        cx = cr && !pte_word[2] && !pte_word[3] && !seg_noexec;        // R4
        mr = 1; mw = 1;
        if (mask_en) begin                                            // R5, R6
            ck  = int'(pte_word[8:4]);
            off = 2 * (31 - ck);
            mw  = !mask_reg[off + 1];
            mr  = !mask_reg[off];
        end
        e_perm = {cx, cw && mw, cr && mr};                            // R7
        need_x = (acc_type == 2);
        need_w = (acc_type == 1);
        need_r = !need_x && !need_w;
        miss = (need_r && !e_perm[0]) || (need_w && !e_perm[1]) || (need_x && !e_perm[2]);
        e_fault = miss;
        e_icode = 0;
        e_dstat = 0;
        if (miss && need_x) e_icode = seg_noexec ? 32'h1000_0000 : 32'h0800_0000;  // R8
        if (miss && !need_x) begin                                    // R9
            if ((need_r && !cr) || (need_w && !cw)) e_dstat |= 32'h0800_0000;
            if ((need_r && !mr) || (need_w && !mw)) e_dstat |= 32'h0020_0000;
            if (need_w) e_dstat |= 32'h0200_0000;
        end
    endtask

    // drive at negedge, result registered at next posedge, compare at following negedge (R10)
    task automatic apply(input string tag);
        logic [2:0] e_perm; logic e_fault; logic [31:0] e_icode, e_dstat;
        model(e_perm, e_fault, e_icode, e_dstat);
        @(negedge clk);
        n_vec++;
        if (perm_q !== e_perm || fault_q !== e_fault || icode_q !== e_icode || dstat_q !== e_dstat) begin
            n_bad++;
            $display("FAIL %s: perm=%b fault=%b icode=%h dstat=%h expected perm=%b fault=%b icode=%h dstat=%h",
                     tag, perm_q, fault_q, icode_q, dstat_q, e_perm, e_fault, e_icode, e_dstat);
        end
    endtask

    task automatic set_code(input int c);
        pte_word[63]  = c[2];
        pte_word[1:0] = c[1:0];
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        mask_en = 1; mask_reg = '1; acc_type = 2;
        repeat (3) @(negedge clk);
        n_vec++;
        if ({perm_q, fault_q, icode_q, dstat_q} !== '0) begin
            n_bad++;
            $display("FAIL R1: outputs=%h expected 0", {perm_q, fault_q, icode_q, dstat_q});
        end
        rst_n = 1;
        mask_en = 0; mask_reg = '0; acc_type = 0;

        // R2: key selection by privilege
        for (int p = 0; p < 2; p++) begin
            for (int ku = 0; ku < 2; ku++) begin
                for (int ks = 0; ks < 2; ks++) begin
                    priv_user = p[0]; seg_key_user = ku[0]; seg_key_super = ks[0];
                    set_code(0); acc_type = 0; apply("R2");
                    set_code(1); acc_type = 1; apply("R2");
                end
            end
        end

        // R3: full code table, both keys, all access types
        for (int k = 0; k < 2; k++) begin
            for (int c = 0; c < 8; c++) begin
                for (int a = 0; a < 4; a++) begin
                    priv_user = 0; seg_key_super = k[0];
                    set_code(c); acc_type = a[1:0]; apply("R3");
                end
            end
        end

        // R4 / R8: execute bars and fetch codes
        seg_key_super = 0; priv_user = 0; set_code(0);
        for (int b = 0; b < 8; b++) begin
            pte_word[2] = b[0]; pte_word[3] = b[1]; seg_noexec = b[2];
            acc_type = 2; apply("R4");
            set_code(4); apply("R8");
            set_code(0);
        end
        pte_word[3:2] = 0; seg_noexec = 0;

        // R5: mask disabled grants all
        mask_en = 0; mask_reg = '1;
        for (int a = 0; a < 3; a++) begin acc_type = a[1:0]; apply("R5"); end

        // R6: mask field at both ends of the key range
        mask_en = 1;
        for (int key = 0; key < 32; key += 31) begin
            pte_word[8:4] = key[4:0];
            for (int f = 0; f < 4; f++) begin
                mask_reg = '0;
                mask_reg[2*(31-key) +: 2] = f[1:0];
                for (int a = 0; a < 3; a++) begin acc_type = a[1:0]; apply("R6"); end
                mask_reg = ~mask_reg;    // all other fields set, selected field inverted
                for (int a = 0; a < 3; a++) begin acc_type = a[1:0]; apply("R6"); end
            end
        end

        // R9: store denied by both sources, load by mask only, load by code only
        pte_word[8:4] = 5'd7; mask_reg = '0; mask_reg[2*(31-7) +: 2] = 2'b11;
        set_code(3); acc_type = 1; apply("R9");
        set_code(0); acc_type = 0; apply("R9");
        mask_reg = '0; set_code(5); acc_type = 3; apply("R9");

        // R7 / R10: random mix, back-to-back vectors
        for (int i = 0; i < 3000; i++) begin
            pte_word = {$urandom, $urandom};
            mask_reg = {$urandom, $urandom};
            {seg_key_user, seg_key_super, seg_noexec, priv_user, mask_en} = 5'($urandom);
            acc_type = 2'($urandom);
            apply("R7");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule